// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

The engine moves received frames into memory buffers under the control of a ring of descriptors. Each descriptor has three 16-bit words: a status word, a length word and a buffer start address. The descriptors sit in a small internal store, which software fills and inspects through a word-wide port. Software gives a descriptor to the engine by setting its empty bit. It then writes the polling-restart register with bit 24 set.

Once started, the engine loads the current descriptor. If that descriptor is empty, the engine waits for a frame on a byte-stream input. It writes each byte to a buffer-write port at consecutive addresses, counting up from the descriptor's buffer address. When the frame ends, the engine writes the byte count, which includes the 4-byte check sequence, back into the descriptor. It also clears the empty bit and records the error flags, then moves to the next descriptor. The ring ends at whichever descriptor has its wrap bit set, and the next descriptor after that one is the ring start index. If the engine meets a descriptor that software has not handed over, it stops and waits for the next restart write.

Top module: `rxr_engine`

## Requirements
- R1: After reset `active` is 0, `rxf_event` is 0, `drop_count` is 0, `buf_we` is 0, and every descriptor word reads 0.
- R2: A write on `rdes_wr` while `enable` is 1 and `rdes_wdata` bit 24 is 1 restarts polling, and `active` is 1 in the cycle after the write. A write with bit 24 clear, or a write made while `enable` is 0, leaves `active` at 0.
- R3: Each byte of an accepted frame appears on `buf_we`/`buf_wdata`. Byte i is written at address (descriptor buffer address + i), in arrival order.
- R4: When a frame completes, the length word becomes the full received byte count. In the status word, bit 15 (empty) is cleared and bit 14 (wrap) keeps its value.
- R5: After a descriptor with bit 14 set, the next descriptor used is `ring_start`. After any other descriptor, the next one is the following index, counting modulo NUM_DESC.
- R6: When the loaded descriptor has bit 15 clear, `active` falls to 0 and no buffer writes take place until the next restart.
- R7: A frame shorter than MIN_FRAME (64) bytes sets status bit 0 (short).
- R8: A frame longer than MAX_FRAME (1518) bytes sets status bit 1 (long). Bytes at offsets of MAX_BUF (1520) and above are not written to the buffer. Status bits 5:0 are all 0 for a frame of legal length.
- R9: A frame whose first byte arrives while the engine is not waiting on an empty descriptor is dropped in full. `drop_count` increases by exactly one for that frame.
- R10: `rxf_event` goes to 1 when each frame completes and stays there until a cycle with `rxf_clr` at 1. If a completion and a clear fall in the same cycle, the completion wins.
- R11: With the software port, `sw_sel` 0 selects the status word, 1 the length word and 2 the buffer address. `sw_we` writes the selected word of descriptor `sw_idx`, and `sw_rdata` shows that word combinationally.

Top module ports are listed in port order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Receive enable |
| rdes_wr | input | 1 | Write strobe of the polling-restart register |
| rdes_wdata | input | 32 | Data for the restart register; bit 24 starts polling |
| ring_start | input | IDX_W | Index of the first descriptor in the ring |
| sw_we | input | 1 | Software descriptor word write |
| sw_idx | input | IDX_W | Descriptor index for software access |
| sw_sel | input | 2 | Word select: 0 status, 1 length, 2 buffer address |
| sw_wdata | input | 16 | Software write data |
| sw_rdata | output | 16 | Selected descriptor word |
| rx_valid | input | 1 | Received byte valid |
| rx_data | input | 8 | Received byte |
| rx_last | input | 1 | Marks the final byte of a frame |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_addr | output | 16 | Buffer byte address |
| buf_wdata | output | 8 | Buffer byte data |
| active | output | 1 | Polling in progress |
| rxf_event | output | 1 | Frame-complete event |
| rxf_clr | input | 1 | Clears `rxf_event` |
| drop_count | output | 16 | Count of dropped frames |

## Verification
A wrong ring index shows up within one frame. The buffer addresses start at the wrong base, and the written-back status lands in a different descriptor than expected, so reading the descriptors through the software port exposes it. A stuck byte counter or a missed end-of-frame corrupts the length word and the address sequence of the same frame. A faulty drop flag misplaces `drop_count` on the very next frame that arrives while the engine is stopped. A wrong stop decision leaves `active` high in the cycle right after the non-empty descriptor is loaded.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    typedef enum logic [2:0] {
        ST_STOP  = 3'd0,
        ST_FETCH = 3'd1,
        ST_WAIT  = 3'd2,
        ST_RECV  = 3'd3,
        ST_WB    = 3'd4
    } rxr_state_e;

    localparam int EMPTY_BIT     = 15;
    localparam int WRAP_BIT      = 14;
    localparam int ERR_SHORT_BIT = 0;
    localparam int ERR_LONG_BIT  = 1;
    localparam int KICK_BIT      = 24;
    localparam int ERR_W         = 6;
endpackage

// File: rtl/rxr_desc_ram.sv
module rxr_desc_ram #(
    parameter int NUM_DESC = 8,
    parameter int WORD_W   = 16,
    parameter int IDX_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_we,
    input  logic [IDX_W-1:0]  sw_idx,
    input  logic [1:0]        sw_sel,
    input  logic [WORD_W-1:0] sw_wdata,
    output logic [WORD_W-1:0] sw_rdata,
    input  logic [IDX_W-1:0]  eng_idx,
    output logic [WORD_W-1:0] eng_status,
    output logic [WORD_W-1:0] eng_buf,
    input  logic              wb_en,
    input  logic [WORD_W-1:0] wb_status,
    input  logic [WORD_W-1:0] wb_len
);
    logic [WORD_W-1:0] st_mem [NUM_DESC];
    logic [WORD_W-1:0] ln_mem [NUM_DESC];
    logic [WORD_W-1:0] ad_mem [NUM_DESC];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_DESC; i++) begin
                st_mem[i] <= '0;
                ln_mem[i] <= '0;
                ad_mem[i] <= '0;
            end
        end else begin
            if (sw_we) begin
                case (sw_sel)
                    2'd0:    st_mem[sw_idx] <= sw_wdata;
                    2'd1:    ln_mem[sw_idx] <= sw_wdata;
                    2'd2:    ad_mem[sw_idx] <= sw_wdata;
                    default: ;
                endcase
            end
            // engine write-back takes precedence over a same-cycle software write
            if (wb_en) begin
                st_mem[eng_idx] <= wb_status;
                ln_mem[eng_idx] <= wb_len;
            end
        end
    end

    always_comb begin
        case (sw_sel)
            2'd0:    sw_rdata = st_mem[sw_idx];
            2'd1:    sw_rdata = ln_mem[sw_idx];
            2'd2:    sw_rdata = ad_mem[sw_idx];
            default: sw_rdata = '0;
        endcase
    end

    assign eng_status = st_mem[eng_idx];
    assign eng_buf    = ad_mem[eng_idx];
endmodule

// File: rtl/rxr_len_check.sv
module rxr_len_check
    import rxr_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int MIN_FRAME = 64,
    parameter int MAX_FRAME = 1518
) (
    input  logic [LEN_W-1:0] len,
    output logic [ERR_W-1:0] err
);
    always_comb begin
        err = '0;
        err[ERR_SHORT_BIT] = (32'(len) < MIN_FRAME);
        err[ERR_LONG_BIT]  = (32'(len) > MAX_FRAME);
    end
endmodule

// File: rtl/rxr_engine.sv
module rxr_engine
    import rxr_pkg::*;
#(
    parameter int NUM_DESC  = 8,
    parameter int MIN_FRAME = 64,
    parameter int MAX_FRAME = 1518,
    parameter int MAX_BUF   = 1520,
    parameter int DROP_W    = 16,
    localparam int IDX_W    = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1,
    localparam int WORD_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              rdes_wr,
    input  logic [31:0]       rdes_wdata,
    input  logic [IDX_W-1:0]  ring_start,
    input  logic              sw_we,
    input  logic [IDX_W-1:0]  sw_idx,
    input  logic [1:0]        sw_sel,
    input  logic [WORD_W-1:0] sw_wdata,
    output logic [WORD_W-1:0] sw_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    output logic              buf_we,
    output logic [WORD_W-1:0] buf_addr,
    output logic [7:0]        buf_wdata,
    output logic              active,
    output logic              rxf_event,
    input  logic              rxf_clr,
    output logic [DROP_W-1:0] drop_count
);
    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(NUM_DESC - 1);
    localparam logic [WORD_W-1:0] CNT_MAX  = '1;

    typedef struct packed {
        rxr_state_e        state;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] cnt;
        logic [WORD_W-1:0] base;
        logic              dropping;
        logic              active;
        logic              rxf;
        logic [DROP_W-1:0] drops;
    } eng_t;

    eng_t q, d;

    logic [WORD_W-1:0] eng_status, eng_buf, wb_status;
    logic              wb_en;
    logic [ERR_W-1:0]  err;
    logic              kick, accept, in_frame;

    rxr_desc_ram #(.NUM_DESC(NUM_DESC), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_ram (
        .clk(clk), .rst_n(rst_n),
        .sw_we(sw_we), .sw_idx(sw_idx), .sw_sel(sw_sel),
        .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
        .eng_idx(q.idx), .eng_status(eng_status), .eng_buf(eng_buf),
        .wb_en(wb_en), .wb_status(wb_status), .wb_len(q.cnt)
    );

    rxr_len_check #(.LEN_W(WORD_W), .MIN_FRAME(MIN_FRAME), .MAX_FRAME(MAX_FRAME)) u_len (
        .len(q.cnt), .err(err)
    );

    always_comb begin
        d         = q;
        buf_we    = 1'b0;
        buf_addr  = WORD_W'(q.base + q.cnt);
        buf_wdata = rx_data;
        wb_en     = 1'b0;
        wb_status = eng_status;
        kick      = rdes_wr && rdes_wdata[KICK_BIT] && enable;
        accept    = (q.state == ST_WAIT) && !q.dropping && enable;
        in_frame  = (q.state == ST_RECV);
        d.rxf     = q.rxf & ~rxf_clr;

        // frames that start while no empty descriptor is waiting are dropped whole
        if (rx_valid && !accept && !in_frame) begin
            if (!q.dropping) begin
                d.drops    = q.drops + 1'b1;
                d.dropping = !rx_last;
            end else if (rx_last) begin
                d.dropping = 1'b0;
            end
        end

        case (q.state)
            ST_STOP: begin
                if (kick) begin
                    d.state  = ST_FETCH;
                    d.active = 1'b1;
                end
            end
            ST_FETCH: begin
                if (enable && eng_status[EMPTY_BIT]) begin
                    d.state = ST_WAIT;
                    d.base  = eng_buf;
                    d.cnt   = '0;
                end else begin
                    d.state  = ST_STOP;
                    d.active = 1'b0;
                end
            end
            ST_WAIT: begin
                if (!enable) begin
                    d.state  = ST_STOP;
                    d.active = 1'b0;
                end else if (accept && rx_valid) begin
                    buf_we   = (MAX_BUF > 0);
                    buf_addr = q.base;
                    d.cnt    = WORD_W'(1);
                    d.state  = rx_last ? ST_WB : ST_RECV;
                end
            end
            ST_RECV: begin
                if (rx_valid) begin
                    buf_we = (32'(q.cnt) < MAX_BUF);
                    if (q.cnt != CNT_MAX) d.cnt = q.cnt + 1'b1;
                    if (rx_last) d.state = ST_WB;
                end
            end
            ST_WB: begin
                wb_en                = 1'b1;
                wb_status[EMPTY_BIT] = 1'b0;
                wb_status[ERR_W-1:0] = err;
                d.rxf                = 1'b1;
                d.state              = ST_FETCH;
                if (eng_status[WRAP_BIT])   d.idx = ring_start;
                else if (q.idx == LAST_IDX) d.idx = '0;
                else                        d.idx = q.idx + 1'b1;
            end
            default: begin
                d.state  = ST_STOP;
                d.active = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state    <= ST_STOP;
            q.idx      <= '0;
            q.cnt      <= '0;
            q.base     <= '0;
            q.dropping <= 1'b0;
            q.active   <= 1'b0;
            q.rxf      <= 1'b0;
            q.drops    <= '0;
        end else begin
            q <= d;
        end
    end

    assign active     = q.active;
    assign rxf_event  = q.rxf;
    assign drop_count = q.drops;
endmodule

module rxr_engine_chk #(
    parameter int DROP_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              rdes_wr,
    input logic [31:0]       rdes_wdata,
    input logic              rx_valid,
    input logic              buf_we,
    input logic [15:0]       buf_addr,
    input logic              active,
    input logic              rxf_event,
    input logic [DROP_W-1:0] drop_count
);
    AST_KICK_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (rdes_wr && rdes_wdata[24] && enable && !active) |=> active); // R2

    AST_WRITE_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> active); // R6

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_we && $past(buf_we)) |-> (buf_addr == 16'($past(buf_addr) + 1'b1))); // R3

    AST_DROP_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_count != $past(drop_count)) |-> $past(rx_valid)); // R9

    AST_EVENT_FROM_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rxf_event) |-> $past(active)); // R10
endmodule

bind rxr_engine rxr_engine_chk #(.DROP_W(DROP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .rdes_wr(rdes_wr),
    .rdes_wdata(rdes_wdata), .rx_valid(rx_valid), .buf_we(buf_we),
    .buf_addr(buf_addr), .active(active), .rxf_event(rxf_event),
    .drop_count(drop_count)
);

// File: tb/rxr_engine_tb.sv
module rxr_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int IDX_W = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b1;
    logic        rdes_wr = 1'b0;
    logic [31:0] rdes_wdata = '0;
    logic [IDX_W-1:0] ring_start = '0;
    logic        sw_we = 1'b0;
    logic [IDX_W-1:0] sw_idx = '0;
    logic [1:0]  sw_sel = '0;
    logic [15:0] sw_wdata = '0;
    logic [15:0] sw_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_last = 1'b0;
    logic        buf_we;
    logic [15:0] buf_addr;
    logic [7:0]  buf_wdata;
    logic        active;
    logic        rxf_event;
    logic        rxf_clr = 1'b0;
    logic [15:0] drop_count;

    int total = 0;
    int fails = 0;

    int          mon_cnt = 0;
    int          mon_bad = 0;
    logic [15:0] mon_first = '0;
    logic [15:0] exp_base = '0;
    logic [7:0]  seed = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxr_engine u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .rdes_wr(rdes_wr),
        .rdes_wdata(rdes_wdata), .ring_start(ring_start), .sw_we(sw_we),
        .sw_idx(sw_idx), .sw_sel(sw_sel), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
        .active(active), .rxf_event(rxf_event), .rxf_clr(rxf_clr),
        .drop_count(drop_count)
    );

    always @(posedge clk) begin
        if (buf_we) begin
            if (mon_cnt == 0) mon_first <= buf_addr;
            if (buf_wdata !== (8'(buf_addr - exp_base) ^ seed)) mon_bad <= mon_bad + 1;
            mon_cnt <= mon_cnt + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sw_write(input int idx, input int sel, input logic [15:0] val);
        @(negedge clk);
        sw_we = 1'b1; sw_idx = IDX_W'(idx); sw_sel = 2'(sel); sw_wdata = val;
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    task automatic sw_read(input int idx, input int sel, output logic [15:0] val);
        sw_idx = IDX_W'(idx); sw_sel = 2'(sel);
        #1 val = sw_rdata;
    endtask

    task automatic kick(input logic [31:0] val);
        @(negedge clk);
        rdes_wr = 1'b1; rdes_wdata = val;
        @(negedge clk);
        rdes_wr = 1'b0; rdes_wdata = '0;
    endtask

    task automatic send_frame(input int n, input logic [7:0] s);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = 8'(i) ^ s; rx_last = (i == n - 1);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    task automatic mon_reset(input logic [15:0] b, input logic [7:0] s);
        mon_cnt = 0; mon_bad = 0; exp_base = b; seed = s;
    endtask

    // each entry: frame length in bits 31:16, expected status error bits in 15:0
    localparam int NV = 7;
    localparam logic [31:0] VEC [NV] = '{
        {16'd64,   16'h0000},
        {16'd63,   16'h0001},
        {16'd1518, 16'h0000},
        {16'd1519, 16'h0002},
        {16'd100,  16'h0000},
        {16'd1,    16'h0001},
        {16'd1525, 16'h0002}
    };

    initial begin
        repeat (150000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        logic [15:0] drops0;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 active", {31'd0, active}, 0);
        chk("R1 event", {31'd0, rxf_event}, 0);
        chk("R1 drops", {16'd0, drop_count}, 0);
        chk("R1 buf_we", {31'd0, buf_we}, 0);
        sw_read(5, 0, rd); chk("R1 desc status", {16'd0, rd}, 0);
        sw_read(5, 2, rd); chk("R1 desc addr", {16'd0, rd}, 0);

        // R2 ignored restart writes
        kick(32'h0080_0000);
        chk("R2 bit24 clear ignored", {31'd0, active}, 0);
        enable = 1'b0;
        kick(32'h0100_0000);
        chk("R2 disabled ignored", {31'd0, active}, 0);
        enable = 1'b1;
        // R2 valid restart on a non-empty descriptor: active one cycle, then R6 stop
        kick(32'h0100_0000);
        chk("R2 restart active", {31'd0, active}, 1);
        @(negedge clk);
        chk("R6 stop on owned descriptor", {31'd0, active}, 0);

        // R11 software port round trip
        sw_write(6, 1, 16'hBEEF);
        sw_read(6, 1, rd); chk("R11 length word", {16'd0, rd}, 32'hBEEF);
        sw_read(6, 3, rd); chk("R11 unused select", {16'd0, rd}, 0);

        // table of frames on a one-descriptor ring (R3 R4 R7 R8 R10)
        for (int k = 0; k < NV; k++) begin
            int          flen;
            logic [15:0] ferr;
            logic [15:0] fbase;
            int          exp_w;
            flen  = int'(VEC[k][31:16]);
            ferr  = VEC[k][15:0];
            fbase = 16'(16'h0800 * (k + 1));
            exp_w = (flen < 1520) ? flen : 1520;
            sw_write(0, 2, fbase);
            sw_write(0, 1, 16'h0000);
            sw_write(0, 0, 16'hC000);
            mon_reset(fbase, 8'(k * 17));
            kick(32'h0100_0000);
            idle(3);
            send_frame(flen, 8'(k * 17));
            idle(6);
            sw_read(0, 1, rd); chk("R4 length", {16'd0, rd}, 32'(flen));
            sw_read(0, 0, rd); chk("R4 R7 R8 status", {16'd0, rd}, {16'd0, 16'h4000 | ferr});
            chk("R3 R8 byte writes", 32'(mon_cnt), 32'(exp_w));
            chk("R3 first address", {16'd0, mon_first}, {16'd0, fbase});
            chk("R3 data", 32'(mon_bad), 0);
            chk("R6 stopped after ring", {31'd0, active}, 0);
            chk("R10 event set", {31'd0, rxf_event}, 1);
            @(negedge clk); rxf_clr = 1'b1;
            @(negedge clk); rxf_clr = 1'b0;
            chk("R10 event cleared", {31'd0, rxf_event}, 0);
        end

        // R5 ring walk: 0 -> 1 (wrap) -> ring_start 3 -> 4 (owned, stop)
        ring_start = 3'd3;
        sw_write(0, 2, 16'h0100); sw_write(0, 0, 16'h8000);
        sw_write(1, 2, 16'h0200); sw_write(1, 0, 16'hC000);
        sw_write(3, 2, 16'h0300); sw_write(3, 0, 16'h8000);
        kick(32'h0100_0000);
        idle(3);
        mon_reset(16'h0100, 8'h11); send_frame(70, 8'h11); idle(4);
        chk("R5 first descriptor", {16'd0, mon_first}, 32'h0100);
        mon_reset(16'h0200, 8'h22); send_frame(80, 8'h22); idle(4);
        chk("R5 next index", {16'd0, mon_first}, 32'h0200);
        mon_reset(16'h0300, 8'h33); send_frame(90, 8'h33); idle(4);
        chk("R5 wrap to ring start", {16'd0, mon_first}, 32'h0300);
        chk("R5 ring data", 32'(mon_bad), 0);
        chk("R6 stop at owned descriptor", {31'd0, active}, 0);
        sw_read(0, 1, rd); chk("R4 ring length", {16'd0, rd}, 70);
        sw_read(1, 0, rd); chk("R4 wrap bit kept", {16'd0, rd}, 32'h4000);
        sw_read(3, 0, rd); chk("R4 empty cleared", {16'd0, rd}, 0);

        // R9 frame arriving while stopped is dropped once, with no writes
        drops0 = drop_count;
        mon_reset(16'h0000, 8'h00);
        send_frame(20, 8'h00); idle(2);
        chk("R9 one drop per frame", {16'd0, drop_count}, {16'd0, 16'(drops0 + 1)});
        chk("R6 no writes while stopped", 32'(mon_cnt), 0);
        send_frame(1, 8'h00); idle(2);
        chk("R9 single-byte frame dropped", {16'd0, drop_count}, {16'd0, 16'(drops0 + 2)});

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule